// File: doc/BRIEF.md
# FM Algorithm Modulation Router

This block sits beside a time-shared FM operator core and decides what perturbs the phase of each operator. The core works through sixteen voices and six operators in a fixed order. It handles operator 6 for voices 0 to 15, then operator 5 for all voices, and so on down to operator 1. Every active slot hands the router the finished output of one operator, together with that operator's number and its voice. The router returns, one cycle later, the modulation word for the operator that the core prepares next for the same voice.

A built-in control table holds one 9-bit word for each of the 32 algorithms and each arriving operator. Each word picks the modulation source and drives a per-voice memory register. That register either accumulates modulators or builds the voice's audio sum. The word also controls a two-deep per-voice feedback history. Self-feedback is smoothed by averaging the two most recent captured values and is attenuated by a power of two. When operator 1 arrives, the memory register holds the finished mix for that voice, and the block presents it with the voice number. The output-count code of the control word is passed along for the level compensation stage downstream.

Top module: `fmr_mod_router`

## Requirements
- R1: While reset is low and on the first cycle after it, `mod_valid`, `mix_valid`, `mod_out` and `mix_out` are zero. All memory and feedback storage starts at zero.
- R2: Every slot with `slot_valid` high produces `mod_valid` high on the next cycle. Source code 0 gives a zero `mod_out`, and code 1 gives the slot's `op_value` unchanged.
- R3: Source code 2 gives the saturating sum, clamped to -8192..8191, of `op_value` and the value the same voice stored in memory during its previous slot.
- R4: Source code 3 gives the memory value that the same voice stored during its previous slot.
- R5: The memory bits C and D act as follows: 00 clears the memory, 01 loads `op_value`, 10 keeps the stored value, and 11 stores the saturating sum of the stored value and `op_value`.
- R6: When the feedback-capture bit is 1, `op_value` becomes the voice's newest feedback value and the previous newest moves to second place. When it is 0, both are kept.
- R7: Source code 4 gives the scaled newest feedback value. Source code 5 gives the scaled average of the two feedback values: their sum, arithmetically shifted right by one.
- R8: Feedback scaling with `fb_level` L from 1 to 7 is an arithmetic right shift by 7-L. With L=0, source codes 4 and 5 give zero.
- R9: Slots arrive voice-interleaved in ascending voice order. Each voice's stored state is the state written by that voice's slot one operator earlier. Cycles with `slot_valid` low change neither the storage nor `mod_out`.
- R10: A slot with `src_op`=1 raises `mix_valid` on the next cycle. `mix_out` then carries that voice's newly written memory value, and `mix_voice` carries the slot's `voice_id`. At every other time `mix_valid` is low.
- R11: `com_out` carries the 3-bit output-count code of the control word used by the slot.
- R12: The control word is selected by `alg_sel` (algorithm number minus one) and `src_op` (the arriving operator number, 1 to 6). Entries are written as source/capture,C,D/count for operators 6 down to 1. Algorithm 8 is 1/000/0, 5/001/0, 2/111/1, 0/001/0, 1/010/1, 0/011/0. Algorithm 21 is 1/001/3, 3/001/3, 5/011/0, 1/110/3, 4/011/3, 0/011/0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_valid | input | 1 | An operator value is present this cycle |
| alg_sel | input | 5 | Algorithm number minus one |
| src_op | input | 3 | Number (1 to 6) of the operator whose output arrives |
| voice_id | input | 4 | Voice of the arriving value |
| fb_level | input | 3 | Feedback attenuation level, 0 disables feedback |
| op_value | input | 14 | Arriving operator output, two's complement |
| mod_out | output | 14 | Modulation word for the next operator of the voice |
| mod_valid | output | 1 | `mod_out` and `com_out` belong to a slot |
| com_out | output | 3 | Output-count code of the slot's control word |
| mix_out | output | 14 | Finished audio sum of a voice |
| mix_valid | output | 1 | `mix_out` is new this cycle |
| mix_voice | output | 4 | Voice that `mix_out` belongs to |

## Verification
The hardest states to reach are those that depend on history. Averaged self-feedback, the delayed memory tap and the saturating accumulate all read values written sixteen valid slots earlier, or a whole round earlier in the case of the feedback pair. A wrong voice alignment therefore shows up only after several full rounds. The stimulus runs complete 96-slot rounds of algorithms 8 and 21, including rounds pinned at both extremes to force clamping. It varies the feedback level, including zero, and scatters idle cycles between slots so that a design which advances its storage on idle cycles drifts out of alignment with the model.

// File: rtl/fmr_pkg.sv
package fmr_pkg;

    localparam int SAMPLE_W = 14;
    localparam int CTRL_W   = 9;
    localparam int OPS      = 6;

    // Modulation source choice carried in the control word
    typedef enum logic [2:0] {
        SRC_NONE    = 3'd0,
        SRC_DIRECT  = 3'd1,
        SRC_SUM     = 3'd2,
        SRC_MEM     = 3'd3,
        SRC_FB_LAST = 3'd4,
        SRC_FB_AVG  = 3'd5
    } src_e;

    // Memory register action, {C, D}
    typedef enum logic [1:0] {
        MEM_CLEAR = 2'b00,
        MEM_LOAD  = 2'b01,
        MEM_HOLD  = 2'b10,
        MEM_ACCUM = 2'b11
    } mem_op_e;

    typedef struct packed {
        logic [2:0] sel;
        logic       fb_load;
        logic [1:0] mem_cd;
        logic [2:0] com;
    } ctrl_word_t;

    function automatic logic [CTRL_W-1:0] cw(input int sel, input logic [2:0] fcd, input int com);
        return {3'(sel), fcd, 3'(com)};
    endfunction

    // One row per algorithm; operator 6 in the top slice, operator 1 in the bottom
    function automatic logic [OPS*CTRL_W-1:0] alg_row(input logic [4:0] alg);
        logic [OPS*CTRL_W-1:0] r;
        unique case (alg)
            5'd0:  r = {cw(1,3'b100,0), cw(1,3'b000,0), cw(1,3'b000,1), cw(0,3'b001,0), cw(1,3'b010,1), cw(5,3'b011,0)};
            5'd1:  r = {cw(1,3'b000,0), cw(1,3'b000,0), cw(1,3'b000,1), cw(5,3'b001,0), cw(1,3'b110,1), cw(0,3'b011,0)};
            5'd2:  r = {cw(1,3'b100,0), cw(1,3'b000,1), cw(0,3'b001,0), cw(1,3'b010,0), cw(1,3'b010,1), cw(5,3'b011,0)};
            5'd3:  r = {cw(1,3'b000,0), cw(1,3'b000,1), cw(0,3'b101,0), cw(1,3'b010,0), cw(1,3'b010,1), cw(5,3'b011,0)};
            5'd4:  r = {cw(1,3'b100,2), cw(0,3'b001,0), cw(1,3'b010,2), cw(0,3'b011,0), cw(1,3'b010,2), cw(5,3'b011,0)};
            5'd5:  r = {cw(1,3'b000,2), cw(0,3'b101,0), cw(1,3'b010,2), cw(0,3'b011,0), cw(1,3'b010,2), cw(5,3'b011,0)};
            5'd6:  r = {cw(1,3'b100,0), cw(0,3'b001,0), cw(2,3'b011,1), cw(0,3'b001,0), cw(1,3'b010,1), cw(5,3'b011,0)};
            5'd7:  r = {cw(1,3'b000,0), cw(5,3'b001,0), cw(2,3'b111,1), cw(0,3'b001,0), cw(1,3'b010,1), cw(0,3'b011,0)};
            5'd8:  r = {cw(1,3'b000,0), cw(0,3'b001,0), cw(2,3'b011,1), cw(5,3'b001,0), cw(1,3'b110,1), cw(0,3'b011,0)};
            5'd9:  r = {cw(0,3'b001,0), cw(2,3'b011,1), cw(5,3'b001,0), cw(1,3'b110,0), cw(1,3'b010,1), cw(0,3'b011,0)};
            5'd10: r = {cw(0,3'b101,0), cw(2,3'b011,1), cw(0,3'b001,0), cw(1,3'b010,0), cw(1,3'b010,1), cw(5,3'b011,0)};
            5'd11: r = {cw(0,3'b001,0), cw(0,3'b011,0), cw(2,3'b011,1), cw(5,3'b001,0), cw(1,3'b110,1), cw(0,3'b011,0)};
            5'd12: r = {cw(0,3'b101,0), cw(0,3'b011,0), cw(2,3'b011,1), cw(0,3'b001,0), cw(1,3'b010,1), cw(5,3'b011,0)};
            5'd13: r = {cw(0,3'b101,0), cw(2,3'b011,0), cw(1,3'b000,1), cw(0,3'b001,0), cw(1,3'b010,1), cw(5,3'b011,0)};
            5'd14: r = {cw(0,3'b001,0), cw(2,3'b011,0), cw(1,3'b000,1), cw(5,3'b001,0), cw(1,3'b110,1), cw(0,3'b011,0)};
            5'd15: r = {cw(1,3'b100,0), cw(0,3'b001,0), cw(1,3'b010,0), cw(0,3'b011,0), cw(2,3'b011,0), cw(5,3'b001,0)};
            5'd16: r = {cw(1,3'b000,0), cw(0,3'b001,0), cw(1,3'b010,0), cw(5,3'b011,0), cw(2,3'b111,0), cw(0,3'b001,0)};
            5'd17: r = {cw(1,3'b000,0), cw(1,3'b000,0), cw(5,3'b001,0), cw(0,3'b111,0), cw(2,3'b011,0), cw(0,3'b001,0)};
            5'd18: r = {cw(1,3'b100,2), cw(4,3'b001,2), cw(0,3'b011,0), cw(1,3'b010,0), cw(1,3'b010,2), cw(5,3'b011,0)};
            5'd19: r = {cw(0,3'b001,0), cw(2,3'b011,2), cw(5,3'b001,0), cw(1,3'b110,2), cw(4,3'b011,2), cw(0,3'b011,0)};
            5'd20: r = {cw(1,3'b001,3), cw(3,3'b001,3), cw(5,3'b011,0), cw(1,3'b110,3), cw(4,3'b011,3), cw(0,3'b011,0)};
            5'd21: r = {cw(1,3'b100,3), cw(4,3'b001,3), cw(4,3'b011,3), cw(0,3'b011,0), cw(1,3'b010,3), cw(5,3'b011,0)};
            5'd22: r = {cw(1,3'b100,3), cw(4,3'b001,3), cw(0,3'b011,0), cw(1,3'b010,3), cw(0,3'b011,3), cw(5,3'b011,0)};
            5'd23: r = {cw(1,3'b100,4), cw(4,3'b001,4), cw(4,3'b011,4), cw(0,3'b011,4), cw(0,3'b011,4), cw(5,3'b011,0)};
            5'd24: r = {cw(1,3'b100,4), cw(4,3'b001,4), cw(0,3'b011,4), cw(0,3'b011,4), cw(0,3'b011,4), cw(5,3'b011,0)};
            5'd25: r = {cw(0,3'b101,0), cw(2,3'b011,2), cw(0,3'b001,0), cw(1,3'b010,2), cw(0,3'b011,2), cw(5,3'b011,0)};
            5'd26: r = {cw(0,3'b001,0), cw(2,3'b011,2), cw(5,3'b001,0), cw(1,3'b110,2), cw(0,3'b011,2), cw(0,3'b011,0)};
            5'd27: r = {cw(5,3'b001,0), cw(1,3'b110,0), cw(1,3'b010,2), cw(0,3'b011,0), cw(1,3'b010,2), cw(0,3'b011,2)};
            5'd28: r = {cw(1,3'b100,3), cw(0,3'b001,0), cw(1,3'b010,3), cw(0,3'b011,3), cw(0,3'b011,3), cw(5,3'b011,0)};
            5'd29: r = {cw(5,3'b001,0), cw(1,3'b110,0), cw(1,3'b010,3), cw(0,3'b011,3), cw(0,3'b011,3), cw(0,3'b011,3)};
            5'd30: r = {cw(1,3'b100,4), cw(0,3'b001,4), cw(0,3'b011,4), cw(0,3'b011,4), cw(0,3'b011,4), cw(5,3'b011,0)};
            5'd31: r = {cw(0,3'b101,5), cw(0,3'b011,5), cw(0,3'b011,5), cw(0,3'b011,5), cw(0,3'b011,5), cw(5,3'b011,5)};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fmr_ctrl_rom.sv
module fmr_ctrl_rom
    import fmr_pkg::*;
#(
    parameter int ALG_W = 5,
    parameter int OP_W  = 3
) (
    input  logic [ALG_W-1:0] alg_sel,
    input  logic [OP_W-1:0]  src_op,
    output ctrl_word_t       ctrl
);

    logic [OPS*CTRL_W-1:0] row;

    always_comb begin
        row  = alg_row(5'(alg_sel));
        ctrl = '0;
        // operator numbers outside 1..OPS leave an all-zero word
        for (int k = 1; k <= OPS; k++) begin
            if (int'(src_op) == k) begin
                ctrl = ctrl_word_t'(row[(k-1)*CTRL_W +: CTRL_W]);
            end
        end
    end

endmodule

// File: rtl/fmr_voice_line.sv
module fmr_voice_line #(
    parameter int W     = 14,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [DEPTH-1:0][W-1:0] stage;

    // one stage per voice; the tail is the value the same voice wrote last time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage <= '0;
        end else if (adv) begin
            stage <= {stage[DEPTH-2:0], din};
        end
    end

    assign dout = stage[DEPTH-1];

endmodule

// File: rtl/fmr_fb_path.sv
module fmr_fb_path #(
    parameter int W     = 14,
    parameter int DEPTH = 16,
    parameter int LVL_W = 3,
    parameter int HIST  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             load,
    input  logic [W-1:0]     din,
    input  logic [LVL_W-1:0] level,
    output logic [W-1:0]     fb_last,
    output logic [W-1:0]     fb_avg
);

    localparam int LVL_MAX = (1 << LVL_W) - 1;

    logic [HIST-1:0][W-1:0] tap_q;
    logic [HIST-1:0][W-1:0] tap_d;
    logic [W:0]             pair;
    logic [W-1:0]           mean;

    // history taps: index 0 newest; a capture pushes every tap one place down
    for (genvar i = 0; i < HIST; i++) begin : g_hist
        if (i == 0) begin : g_head
            assign tap_d[i] = load ? din : tap_q[i];
        end else begin : g_tail
            assign tap_d[i] = load ? tap_q[i-1] : tap_q[i];
        end
        fmr_voice_line #(.W(W), .DEPTH(DEPTH)) u_line (
            .clk  (clk),
            .rst_n(rst_n),
            .adv  (adv),
            .din  (tap_d[i]),
            .dout (tap_q[i])
        );
    end

    function automatic logic [W-1:0] attenuate(input logic [W-1:0] v, input logic [LVL_W-1:0] lvl);
        logic signed [W-1:0] sv;
        if (lvl == '0) begin
            return '0;
        end
        sv = $signed(v) >>> (LVL_MAX - int'(lvl));
        return sv;
    endfunction

    assign pair    = {tap_q[0][W-1], tap_q[0]} + {tap_q[1][W-1], tap_q[1]};
    assign mean    = pair[W:1];
    assign fb_last = attenuate(tap_q[0], level);
    assign fb_avg  = attenuate(mean, level);

endmodule

// File: rtl/fmr_mod_router.sv
module fmr_mod_router
    import fmr_pkg::*;
#(
    parameter int DATA_W  = SAMPLE_W,
    parameter int VOICES  = 16,
    parameter int LVL_W   = 3,
    parameter int ALG_W   = 5,
    parameter int OP_W    = 3,
    parameter int VOICE_W = $clog2(VOICES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_valid,
    input  logic [ALG_W-1:0]   alg_sel,
    input  logic [OP_W-1:0]    src_op,
    input  logic [VOICE_W-1:0] voice_id,
    input  logic [LVL_W-1:0]   fb_level,
    input  logic [DATA_W-1:0]  op_value,
    output logic [DATA_W-1:0]  mod_out,
    output logic               mod_valid,
    output logic [2:0]         com_out,
    output logic [DATA_W-1:0]  mix_out,
    output logic               mix_valid,
    output logic [VOICE_W-1:0] mix_voice
);

    localparam logic [DATA_W-1:0] MAX_V    = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MIN_V    = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [OP_W-1:0]   FINAL_OP = OP_W'(1);

    function automatic logic [DATA_W-1:0] sat_add(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] b);
        logic [DATA_W:0] s;
        s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
        if (s[DATA_W] != s[DATA_W-1]) begin
            return s[DATA_W] ? MIN_V : MAX_V;
        end
        return s[DATA_W-1:0];
    endfunction

    ctrl_word_t        ctrl;
    logic [2:0]        cur_sel;
    logic [DATA_W-1:0] mem_q;
    logic [DATA_W-1:0] mem_d;
    logic [DATA_W-1:0] mem_sum;
    logic [DATA_W-1:0] fb_last;
    logic [DATA_W-1:0] fb_avg;
    logic [DATA_W-1:0] mod_d;
    logic              last_op;

    fmr_ctrl_rom #(.ALG_W(ALG_W), .OP_W(OP_W)) u_rom (
        .alg_sel(alg_sel),
        .src_op (src_op),
        .ctrl   (ctrl)
    );

    fmr_voice_line #(.W(DATA_W), .DEPTH(VOICES)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (slot_valid),
        .din  (mem_d),
        .dout (mem_q)
    );

    fmr_fb_path #(.W(DATA_W), .DEPTH(VOICES), .LVL_W(LVL_W), .HIST(2)) u_fb (
        .clk    (clk),
        .rst_n  (rst_n),
        .adv    (slot_valid),
        .load   (ctrl.fb_load),
        .din    (op_value),
        .level  (fb_level),
        .fb_last(fb_last),
        .fb_avg (fb_avg)
    );

    assign cur_sel = ctrl.sel;
    assign mem_sum = sat_add(mem_q, op_value);
    assign last_op = (src_op == FINAL_OP);

    // memory register next value
    always_comb begin
        unique case (mem_op_e'(ctrl.mem_cd))
            MEM_CLEAR: mem_d = '0;
            MEM_LOAD:  mem_d = op_value;
            MEM_HOLD:  mem_d = mem_q;
            MEM_ACCUM: mem_d = mem_sum;
        endcase
    end

    // modulation source selector
    always_comb begin
        unique case (src_e'(cur_sel))
            SRC_NONE:    mod_d = '0;
            SRC_DIRECT:  mod_d = op_value;
            SRC_SUM:     mod_d = mem_sum;
            SRC_MEM:     mod_d = mem_q;
            SRC_FB_LAST: mod_d = fb_last;
            SRC_FB_AVG:  mod_d = fb_avg;
            default:     mod_d = '0;
        endcase
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_out   <= '0;
            mod_valid <= 1'b0;
            com_out   <= '0;
            mix_out   <= '0;
            mix_valid <= 1'b0;
            mix_voice <= '0;
        end else begin
            mod_valid <= slot_valid;
            mix_valid <= slot_valid && last_op;
            if (slot_valid) begin
                mod_out <= mod_d;
                com_out <= ctrl.com;
                if (last_op) begin
                    mix_out   <= mem_d;
                    mix_voice <= voice_id;
                end
            end
        end
    end

endmodule

// File: rtl/fmr_mod_router_chk.sv
module fmr_mod_router_chk #(
    parameter int DATA_W = 14,
    parameter int LVL_W  = 3,
    parameter int OP_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_valid,
    input logic [OP_W-1:0]   src_op,
    input logic [LVL_W-1:0]  fb_level,
    input logic [DATA_W-1:0] op_value,
    input logic [2:0]        sel_code,
    input logic [DATA_W-1:0] mod_out,
    input logic              mod_valid,
    input logic              mix_valid
);

    logic live;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= 1'b0;
        end else begin
            live <= 1'b1;
        end
    end

    assert_slot_ack_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
        slot_valid |=> mod_valid)
        else $error("slot without mod_valid");

    assert_sel_none_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
        (slot_valid && sel_code == 3'd0) |=> (mod_out == '0))
        else $error("source 0 gave nonzero modulation");

    assert_sel_direct_R2: assert property (@(posedge clk) disable iff (!rst_n || !live)
        (slot_valid && sel_code == 3'd1) |=> (mod_out == $past(op_value)))
        else $error("source 1 did not pass the operator value");

    assert_fb_off_R8: assert property (@(posedge clk) disable iff (!rst_n || !live)
        (slot_valid && fb_level == '0 && (sel_code == 3'd4 || sel_code == 3'd5)) |=> (mod_out == '0))
        else $error("feedback level 0 leaked feedback");

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || !live)
        !slot_valid |=> ($stable(mod_out) && !mod_valid))
        else $error("idle cycle changed the modulation output");

    assert_mix_mark_R10: assert property (@(posedge clk) disable iff (!rst_n || !live)
        (slot_valid && src_op == OP_W'(1)) |=> mix_valid)
        else $error("operator 1 slot gave no mix");

    assert_mix_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n || !live)
        !(slot_valid && src_op == OP_W'(1)) |=> !mix_valid)
        else $error("mix_valid outside an operator 1 slot");

endmodule

bind fmr_mod_router fmr_mod_router_chk #(.DATA_W(DATA_W), .LVL_W(LVL_W), .OP_W(OP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_valid(slot_valid),
    .src_op    (src_op),
    .fb_level  (fb_level),
    .op_value  (op_value),
    .sel_code  (cur_sel),
    .mod_out   (mod_out),
    .mod_valid (mod_valid),
    .mix_valid (mix_valid)
);

// File: tb/fmr_mod_router_test.sv
module fmr_mod_router_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slot_valid = 1'b0;
    logic [4:0]  alg_sel = '0;
    logic [2:0]  src_op = '0;
    logic [3:0]  voice_id = '0;
    logic [2:0]  fb_level = '0;
    logic [13:0] op_value = '0;
    logic [13:0] mod_out;
    logic        mod_valid;
    logic [2:0]  com_out;
    logic [13:0] mix_out;
    logic        mix_valid;
    logic [3:0]  mix_voice;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fmr_mod_router uut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .alg_sel(alg_sel),
        .src_op(src_op), .voice_id(voice_id), .fb_level(fb_level), .op_value(op_value),
        .mod_out(mod_out), .mod_valid(mod_valid), .com_out(com_out),
        .mix_out(mix_out), .mix_valid(mix_valid), .mix_voice(mix_voice)
    );

    typedef struct {
        logic [13:0] mod;
        logic [2:0]  com;
        bit          is_mix;
        logic [13:0] mix;
        logic [3:0]  voice;
        string       tag;
    } exp_t;

    exp_t q[$];

    // reference state, indexed by voice
    int m_mem[16];
    int m_fb_new[16];
    int m_fb_old[16];

    function automatic int sat(input int v);
        if (v > 8191) return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    function automatic int scale(input int v, input int lvl);
        if (lvl == 0) return 0;
        return v >>> (7 - lvl);
    endfunction

    // control words for the two algorithms the requirements list (R12): {sel, fcd, com}
    function automatic void entry(input int alg, input int op, output int sel, output int fcd, output int com);
        int s6[6] = '{1, 5, 2, 0, 1, 0};
        int f6[6] = '{0, 1, 7, 1, 2, 3};
        int c6[6] = '{0, 0, 1, 0, 1, 0};
        int s21[6] = '{1, 3, 5, 1, 4, 0};
        int f21[6] = '{1, 1, 3, 6, 3, 3};
        int c21[6] = '{3, 3, 0, 3, 3, 0};
        if (alg == 8) begin
            sel = s6[6-op]; fcd = f6[6-op]; com = c6[6-op];
        end else begin
            sel = s21[6-op]; fcd = f21[6-op]; com = c21[6-op];
        end
    endfunction

    function automatic string tag_for(input int sel, input int lvl);
        case (sel)
            0, 1: return "R2 R12";
            2: return "R3 R5 R9";
            3: return "R4 R5 R9";
            default: return (lvl == 0) ? "R8" : "R6 R7 R8 R9";
        endcase
    endfunction

    function automatic int s14(input logic [13:0] v);
        return int'($signed(v));
    endfunction

    task automatic do_slot(input int alg, input int op, input int v, input int lvl, input int val);
        int sel, fcd, com, mh, x, e_mod, new_mem;
        exp_t e;
        entry(alg, op, sel, fcd, com);
        mh = m_mem[v];
        x = val;
        case (sel)
            0: e_mod = 0;
            1: e_mod = x;
            2: e_mod = sat(mh + x);
            3: e_mod = mh;
            4: e_mod = scale(m_fb_new[v], lvl);
            default: e_mod = scale((m_fb_new[v] + m_fb_old[v]) >>> 1, lvl);
        endcase
        case (fcd & 3)
            0: new_mem = 0;
            1: new_mem = x;
            2: new_mem = mh;
            default: new_mem = sat(mh + x);
        endcase
        m_mem[v] = new_mem;
        if (fcd[2]) begin
            m_fb_old[v] = m_fb_new[v];
            m_fb_new[v] = x;
        end
        e.mod = 14'(e_mod);
        e.com = 3'(com);
        e.is_mix = (op == 1);
        e.mix = 14'(new_mem);
        e.voice = 4'(v);
        e.tag = tag_for(sel, lvl);
        @(negedge clk);
        slot_valid = 1'b1;
        alg_sel = 5'(alg - 1);
        src_op = 3'(op);
        voice_id = 4'(v);
        fb_level = 3'(lvl);
        op_value = 14'(x);
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        slot_valid = 1'b0;
        op_value = 14'h1555;
        src_op = 3'd1;
    endtask

    // mode 0 random, 1 max, 2 min, 3 small per-voice
    task automatic run_round(input int alg, input int lvl, input int mode, input bit gaps);
        for (int op = 6; op >= 1; op--) begin
            for (int v = 0; v < 16; v++) begin
                int val;
                case (mode)
                    0: val = int'($urandom % 16384) - 8192;
                    1: val = 8191;
                    2: val = -8192;
                    default: val = (v + 1) * 37 * op - 700;
                endcase
                do_slot(alg, op, v, lvl, val);
                if (gaps && ($urandom % 4 == 0)) idle();
            end
        end
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expectation per valid result
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (mod_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected result", s14(mod_out), 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(mod_out == e.mod, e.tag, s14(mod_out), s14(e.mod));
                    check(com_out == e.com, "R11", int'(com_out), int'(e.com));
                    check(mix_valid == e.is_mix, "R10 mix_valid", int'(mix_valid), int'(e.is_mix));
                    if (e.is_mix) begin
                        check(mix_out == e.mix, "R5 R10 mix_out", s14(mix_out), s14(e.mix));
                        check(mix_voice == e.voice, "R10 mix_voice", int'(mix_voice), int'(e.voice));
                    end
                end
            end else begin
                check(!mix_valid, "R10 mix_valid while idle", int'(mix_valid), 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int v = 0; v < 16; v++) begin
            m_mem[v] = 0; m_fb_new[v] = 0; m_fb_old[v] = 0;
        end
        repeat (3) @(negedge clk);
        check(!mod_valid && !mix_valid, "R1 valids in reset", int'(mod_valid) + int'(mix_valid), 0);
        check(mod_out == '0 && mix_out == '0, "R1 data in reset", s14(mod_out) + s14(mix_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mod_valid && !mix_valid && mod_out == '0, "R1 after reset", s14(mod_out), 0);

        run_round(8, 7, 3, 1'b0);
        run_round(8, 7, 0, 1'b0);
        run_round(8, 5, 0, 1'b1);
        run_round(8, 0, 0, 1'b0);
        run_round(8, 7, 1, 1'b0);
        run_round(8, 7, 1, 1'b0);
        run_round(21, 6, 0, 1'b0);
        run_round(21, 7, 2, 1'b0);
        run_round(21, 7, 2, 1'b1);
        run_round(21, 0, 3, 1'b1);
        run_round(21, 3, 0, 1'b1);
        run_round(8, 1, 0, 1'b1);
        run_round(21, 7, 1, 1'b0);
        idle();
        repeat (4) @(negedge clk);
        check(q.size() == 0, "R2 pending results", q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule